// File: doc/BRIEF.md
# One-Bit Recirculating Delay Line

This block delays a one-bit delta-modulated audio stream by a selectable number of samples. Every stored sample is a single raw modulator bit; nothing is packed into wider words. The storage is an on-chip RAM used as a circular buffer, so the block acts like one very long one-bit shift register.

A separate, variable-rate sample clock marks each sample. Its level arrives on an asynchronous input, and the block synchronises it and turns each rising edge into one internal tick. On every tick the block does three things:
- It reads the bit written a chosen number of ticks earlier.
- It writes either the live input bit or, in hold mode, the bit it has just played out.
- It advances its write pointer by one.

Four coarse lengths, each four times the one before, are chosen by a select code. Delay time between the coarse steps comes from changing the external tick rate. Changing the length or the tick rate never clears the stored audio.

Top module: `onebit_delay_line`

## Requirements
- R1: After reset `bit_out` is 0, the write pointer is zero and no samples count as stored.
- R2: Each rising edge of `smp_en_async` produces exactly one tick. An enable held high for many clock cycles still produces only one tick.
- R3: Code s on `len_sel` selects a length N = 2^(BASE_LOG2 + STEP_LOG2*s). With the defaults the lengths are 16, 64, 256 and 1024 for codes 0, 1, 2 and 3. Once at least N samples are stored, the output on tick k is the bit written on tick k-N.
- R4: While fewer than N samples have been written since reset, the output on tick k is the idle pattern: 1 when k is even and 0 when k is odd, counting the first tick after reset as k = 0.
- R5: When `hold` is 1 on a tick, the bit written on that tick is the bit output on that tick, and `bit_in` is ignored. Stored content therefore repeats with period N.
- R6: `bit_in`, `len_sel` and `hold` are sampled only on ticks. Changes between ticks have no effect on `bit_out`.
- R7: Changing `len_sel` does not clear the memory. On the first tick after a change, the output is already the bit written N_new ticks earlier.
- R8: `bit_out` changes only as the result of a tick, on the fifth rising `clk` edge after `smp_en_async` is first sampled high. It stays stable at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en_async | input | 1 | Sample clock level from an external variable-rate source; each rising edge is one sample |
| bit_in | input | 1 | Live one-bit modulator sample |
| len_sel | input | SEL_W (2) | Coarse length code |
| hold | input | 1 | Recirculate the output bit instead of the live input |
| bit_out | output | 1 | Delayed bit |

## Verification
A pointer that slips or skips by a single step, or a wrong read offset, shows at the port within one delay length of the first primed tick. From then on the output no longer matches the bit written exactly N ticks before. A fill count that is wrong shows as the idle pattern ending early or late, at the N-th tick after reset. A wrong hold path shows N ticks after hold is set, when the looped content fails to repeat. A tick that is duplicated, lost or mis-timed shows at once, because the output is compared on every clock around every sample.

// File: rtl/odl_pkg.sv
package odl_pkg;

    // Address width needed to cover the longest tap.
    function automatic int addr_bits(input int base_log2, input int step_log2, input int taps);
        return base_log2 + step_log2 * (taps - 1);
    endfunction

    // Fewest synchroniser stages accepted.
    localparam int SYNC_MIN = 2;

endpackage

// File: rtl/odl_tick_sync.sv
module odl_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_lvl,
    output logic tick
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
        logic              tick;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], async_lvl};
        st_d.last = st_q.sh[STAGES-1];
        st_d.tick = st_q.sh[STAGES-1] & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R2: a tick lasts one cycle only
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);

endmodule

// File: rtl/odl_bit_ram.sv
module odl_bit_ram #(
    parameter int AW = 10,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit
);

    logic mem_q [DEPTH];
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= mem_q[rd_addr];
        if (wr_en) mem_q[wr_addr] <= wr_bit;
    end

    assign rd_bit = rd_q;

    // R3: the read of a tick and the delayed write never share a cycle
    a_r3_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/odl_len_decode.sv
module odl_len_decode #(
    parameter int BASE_LOG2 = 4,
    parameter int STEP_LOG2 = 2,
    parameter int NUM_TAPS  = 4,
    parameter int AW        = 10,
    localparam int SEL_W    = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1,
    localparam int SLOTS    = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [AW:0]      fill,
    output logic [AW-1:0]    len_lo,
    output logic             primed
);

    logic [AW:0] tap_len [SLOTS];
    logic [AW:0] chosen;

    for (genvar t = 0; t < SLOTS; t++) begin : g_tap
        if (t < NUM_TAPS) begin : g_real
            assign tap_len[t] = (AW+1)'(1) << (BASE_LOG2 + STEP_LOG2 * t);
        end else begin : g_clamp
            assign tap_len[t] = (AW+1)'(1) << (BASE_LOG2 + STEP_LOG2 * (NUM_TAPS - 1));
        end
    end

    always_comb begin
        chosen = tap_len[sel];
        len_lo = chosen[AW-1:0];
        primed = (fill >= chosen);
    end

endmodule

// File: rtl/onebit_delay_line.sv
module onebit_delay_line #(
    parameter int BASE_LOG2   = 4,
    parameter int STEP_LOG2   = 2,
    parameter int NUM_TAPS    = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en_async,
    input  logic             bit_in,
    input  logic [SEL_W-1:0] len_sel,
    input  logic             hold,
    output logic             bit_out
);

    localparam int AW    = odl_pkg::addr_bits(BASE_LOG2, STEP_LOG2, NUM_TAPS);
    localparam int DEPTH = 1 << AW;
    localparam int SYNC_N = (SYNC_STAGES < odl_pkg::SYNC_MIN) ? odl_pkg::SYNC_MIN : SYNC_STAGES;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW:0]   fill;
        logic          stg_vld;
        logic          stg_din;
        logic          stg_hold;
        logic          stg_primed;
        logic          stg_idle;
        logic          dout;
    } st_t;

    st_t st_q, st_d;

    logic          tick;
    logic [AW-1:0] len_lo;
    logic          primed;
    logic          ram_rd_en, ram_wr_en, ram_wr_bit, ram_rd_bit;
    logic [AW-1:0] ram_rd_addr;
    logic          out_bit;

    odl_tick_sync #(.STAGES(SYNC_N)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_lvl (smp_en_async),
        .tick      (tick)
    );

    odl_len_decode #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .NUM_TAPS  (NUM_TAPS),
        .AW        (AW)
    ) dec_i (
        .sel    (len_sel),
        .fill   (st_q.fill),
        .len_lo (len_lo),
        .primed (primed)
    );

    odl_bit_ram #(.AW(AW)) ram_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (ram_rd_en),
        .rd_addr (ram_rd_addr),
        .rd_bit  (ram_rd_bit),
        .wr_en   (ram_wr_en),
        .wr_addr (st_q.wp),
        .wr_bit  (ram_wr_bit)
    );

    always_comb begin
        st_d        = st_q;
        // tick cycle: issue the read and capture the controls
        ram_rd_en   = tick;
        ram_rd_addr = st_q.wp - len_lo;
        st_d.stg_vld = tick;
        if (tick) begin
            st_d.stg_din    = bit_in;
            st_d.stg_hold   = hold;
            st_d.stg_primed = primed;
            st_d.stg_idle   = ~st_q.wp[0];
        end
        // following cycle: write, output, advance
        out_bit    = st_q.stg_primed ? ram_rd_bit : st_q.stg_idle;
        ram_wr_en  = st_q.stg_vld;
        ram_wr_bit = st_q.stg_hold ? out_bit : st_q.stg_din;
        if (st_q.stg_vld) begin
            st_d.dout = out_bit;
            st_d.wp   = st_q.wp + 1'b1;
            if (st_q.fill != (AW+1)'(DEPTH)) st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_out = st_q.dout;

    // R2: every tick enters the stage register
    a_r2_tick_to_stage: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> st_q.stg_vld);

    // R3: the pointer steps by exactly one per sample
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stg_vld |=> (st_q.wp == AW'($past(st_q.wp) + 1'b1)));

    // R8: without a completing sample the output holds
    a_r8_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stg_vld |=> $stable(bit_out));

    // R4: the fill count never passes the memory depth
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= (AW+1)'(DEPTH));

endmodule

// File: tb/onebit_delay_line_tb_top.sv
module onebit_delay_line_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en_async = 1'b0;
    logic       bit_in = 1'b0;
    logic [1:0] len_sel = 2'd0;
    logic       hold = 1'b0;
    logic       bit_out;

    int  n_chk = 0;
    int  n_err = 0;
    int  k = 0;
    bit  prev_out = 1'b0;
    bit  hist [0:16383];

    always #5 clk = ~clk;

    onebit_delay_line dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_en_async (smp_en_async),
        .bit_in       (bit_in),
        .len_sel      (len_sel),
        .hold         (hold),
        .bit_out      (bit_out)
    );

    function automatic int len_of(input int s);
        return 1 << (4 + 2 * s);
    endfunction

    function automatic bit model_out(input int s);
        int n = len_of(s);
        if (k >= n) return hist[k - n];
        return ((k % 2) == 0);
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b (tick %0d)", tag, act, exp, k);
        end
    endtask

    task automatic do_tick(input bit d, input int s, input bit h, input int extra_hi, input string tag);
        bit    exp_o;
        string use_tag;
        exp_o   = model_out(s);
        use_tag = (k >= len_of(s)) ? tag : "R4";
        @(negedge clk);
        bit_in = d; len_sel = 2'(s); hold = h; smp_en_async = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (i < 5) chk("R8", bit_out, prev_out);
            else       chk(use_tag, bit_out, exp_o);
        end
        hist[k]  = h ? exp_o : d;
        k++;
        prev_out = exp_o;
        for (int i = 0; i < extra_hi; i++) begin
            @(negedge clk);
            chk("R2", bit_out, prev_out);
        end
        smp_en_async = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bit_in = 1'($urandom); len_sel = 2'($urandom); hold = 1'($urandom);
            chk("R6", bit_out, prev_out);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_en_async = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", bit_out, 1'b0);
        rst_n = 1'b1;
        k = 0; prev_out = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", bit_out, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // longest length: idle pattern, then delayed playback (R4, R3)
        for (int i = 0; i < 1100; i++) do_tick(1'($urandom), 3, 1'b0, 0, "R3");
        // random length changes with occasional hold (R7)
        for (int i = 0; i < 1400; i++)
            do_tick(1'($urandom), int'($urandom % 4), ($urandom % 8) == 0, 0, "R7");
        // long hold on a short length: content loops (R5)
        for (int i = 0; i < 200; i++) do_tick(1'($urandom), 1, 1'b1, 0, "R5");
        // enable kept high for a long time: one tick each (R2)
        for (int i = 0; i < 20; i++) do_tick(1'($urandom), 0, 1'b0, 15, "R2");
        // second reset: fill restarts, idle pattern from 1 again (R1, R4)
        do_reset();
        for (int i = 0; i < 40; i++) do_tick(1'($urandom), 0, 1'b0, 0, "R3");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule